// File: doc/BRIEF.md
# Supervisor Reset Generator with Watchdog

This block produces the system reset of a processor supervisor. It watches a digitized supply-low comparator flag and a power-good flag that rises once the supply reaches about one volt. While power-good is low the whole block is held in reset and the reset output is active. Reset is also driven active whenever the supply-low flag is set. Once the supply is back above the trip level, reset is released only after a fixed hold-off time.

A watchdog runs while reset is released. Its period is picked by a two-bit selection input, which can also switch it off. Only a falling edge on the chip-select/watchdog input restarts the count; that input passes through a synchronizer first. If the count expires, reset is asserted for the same hold-off time used after a brownout.

Both delays are counted in ticks of one shared prescaler. The prescaler restarts whenever a delay restarts, so every timeout is an exact number of clock cycles. The output models an open-drain pin: an active-low reset level plus a drive enable that is high while reset is active.

Top module: `supv_reset_top`

## Requirements
- R1: While `porOk` is low, `rstOutN` is 0 and `rstDriveEn` is 1.
- R2: After `porOk` rises with `supplyLow` low, `rstOutN` goes high exactly HOLD_TICKS*PRESCALE rising clock edges later.
- R3: When `supplyLow` is 1 at a rising edge while reset is released, `rstOutN` is 0 after that edge.
- R4: While `supplyLow` stays 1, reset stays active. `rstOutN` rises HOLD_TICKS*PRESCALE edges after the first edge at which `supplyLow` is 0.
- R5: If `supplyLow` returns to 1 during the hold-off, the hold-off restarts. Release comes HOLD_TICKS*PRESCALE edges after the final return to 0.
- R6: The watchdog selection `wdSel` is encoded as 00 = WD_SHORT ticks, 01 = WD_MID ticks and 10 = WD_LONG ticks. With no falling edge on `wdIn`, reset asserts exactly period*PRESCALE edges after release.
- R7: `wdSel` = 11 disables the watchdog: reset stays released however long `wdIn` is left unchanged.
- R8: A high-to-low change of `wdIn` restarts the watchdog at the third rising edge after the change. A low-to-high change does not restart it. Regular falling edges inside the period keep reset released.
- R9: A watchdog expiry holds reset active for HOLD_TICKS*PRESCALE edges and then releases it.
- R10: `rstDriveEn` is always the inverse of `rstOutN`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| porOk | input | 1 | Supply above about 1 V; low resets the block asynchronously |
| supplyLow | input | 1 | Supply below trip threshold (synchronous digital flag) |
| wdIn | input | 1 | Chip-select / watchdog strobe input |
| wdSel | input | 2 | Watchdog period selection |
| rstOutN | output | 1 | Reset level, active low |
| rstDriveEn | output | 1 | Open-drain pull-down enable, high while reset is active |

## Verification
The hold-off is measured in edges from four starting points: power-up, a long brownout, a brownout glitch that arrives part-way through the hold-off, and a watchdog expiry. Equal counts show that one shared path serves every reset source. The watchdog is swept over all three periods with a static input, which isolates the tick arithmetic per selection. A late falling edge must shift expiry by its offset plus the three-edge synchronizer delay, while a rising edge must leave expiry unchanged; together these separate edge polarity from level sensitivity. A run of periodic kicks and a long idle period with the watchdog off confirm that no expiry happens when none is due.

// File: rtl/supv_pkg.sv
package supv_pkg;

  typedef enum logic {
    ST_HOLD = 1'b0,
    ST_RUN  = 1'b1
  } supvState_e;

  // strobes from control to datapath
  typedef struct packed {
    logic tbClr;    // restart the shared prescaler
    logic holdClr;  // clear the hold-off counter
    logic holdEn;   // let the hold-off counter advance on ticks
    logic wdClr;    // clear the watchdog counter
    logic wdEn;     // let the watchdog counter advance on ticks
  } ctlStrobe_t;

  localparam logic [1:0] WD_SEL_OFF = 2'b11;

endpackage

// File: rtl/supv_datapath.sv
module supv_datapath
  import supv_pkg::*;
#(
  parameter int PRESCALE    = 125000,
  parameter int HOLD_TICKS  = 200,
  parameter int WD_SHORT    = 200,
  parameter int WD_MID      = 600,
  parameter int WD_LONG     = 1400,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porOk,
  input  logic       wdIn,
  input  logic [1:0] wdSel,
  input  ctlStrobe_t ctl,
  output logic       holdDone,
  output logic       wdExpire,
  output logic       wdFall
);

  localparam int PW = $clog2(PRESCALE + 1);
  localparam int HW = $clog2(HOLD_TICKS + 1);
  localparam int CW = $clog2(WD_LONG + 1);

  logic [PW-1:0] pCnt;
  logic [HW-1:0] holdCnt;
  logic [CW-1:0] wdCnt;
  logic [CW-1:0] wdLimitM1;
  logic          tickRaw;
  logic [SYNC_STAGES-1:0] syncQ;
  logic          wdLast;

  // shared timebase
  assign tickRaw = (pCnt == PW'(PRESCALE - 1));

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk)          pCnt <= '0;
    else if (ctl.tbClr)  pCnt <= '0;
    else if (tickRaw)    pCnt <= '0;
    else                 pCnt <= pCnt + 1'b1;
  end

  // hold-off counter
  assign holdDone = tickRaw && (holdCnt == HW'(HOLD_TICKS - 1));

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk)                       holdCnt <= '0;
    else if (ctl.holdClr)             holdCnt <= '0;
    else if (ctl.holdEn && tickRaw)   holdCnt <= holdDone ? '0 : holdCnt + 1'b1;
  end

  // input synchronizer chain
  generate
    for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_sync
      if (s == 0) begin : g_first
        always_ff @(posedge clk or negedge porOk) begin
          if (!porOk) syncQ[0] <= 1'b0;
          else        syncQ[0] <= wdIn;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge porOk) begin
          if (!porOk) syncQ[s] <= 1'b0;
          else        syncQ[s] <= syncQ[s-1];
        end
      end
    end
  endgenerate

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) wdLast <= 1'b0;
    else        wdLast <= syncQ[SYNC_STAGES-1];
  end

  assign wdFall = wdLast && !syncQ[SYNC_STAGES-1];

  // watchdog period selection
  always_comb begin
    unique case (wdSel)
      2'b00:   wdLimitM1 = CW'(WD_SHORT - 1);
      2'b01:   wdLimitM1 = CW'(WD_MID - 1);
      default: wdLimitM1 = CW'(WD_LONG - 1);
    endcase
  end

  // >= keeps expiry reachable if the selection shrinks mid-count
  assign wdExpire = (wdSel != WD_SEL_OFF) && tickRaw && !wdFall &&
                    (wdCnt >= wdLimitM1);

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk)                               wdCnt <= '0;
    else if (ctl.wdClr || wdSel == WD_SEL_OFF) wdCnt <= '0;
    else if (ctl.wdEn && tickRaw)             wdCnt <= wdExpire ? '0 : wdCnt + 1'b1;
  end

  // R2: a timebase restart leaves the prescaler at zero
  p_tb_restart_r2: assert property (@(posedge clk) disable iff (!porOk)
    ctl.tbClr |=> (pCnt == '0));

  // R4: hold-off counter never runs past its terminal count
  p_hold_bound_r4: assert property (@(posedge clk) disable iff (!porOk)
    holdCnt < HW'(HOLD_TICKS));

  // R8: a detected falling edge restarts the watchdog count
  p_fall_clears_r8: assert property (@(posedge clk) disable iff (!porOk)
    wdFall |=> (wdCnt == '0));

  // R7: watchdog counter idles while switched off
  p_off_idle_r7: assert property (@(posedge clk) disable iff (!porOk)
    (wdSel == WD_SEL_OFF) |=> (wdCnt == '0));

endmodule

// File: rtl/supv_control.sv
module supv_control
  import supv_pkg::*;
(
  input  logic       clk,
  input  logic       porOk,
  input  logic       supplyLow,
  input  logic       holdDone,
  input  logic       wdExpire,
  input  logic       wdFall,
  output ctlStrobe_t ctl,
  output logic       isRun
);

  supvState_e state, stateNxt;
  logic goHold;

  always_ff @(posedge clk or negedge porOk) begin
    if (!porOk) state <= ST_HOLD;
    else        state <= stateNxt;
  end

  always_comb begin
    ctl      = '0;
    stateNxt = state;
    goHold   = 1'b0;
    unique case (state)
      ST_HOLD: begin
        ctl.holdEn  = 1'b1;
        ctl.wdClr   = 1'b1;
        ctl.holdClr = supplyLow;
        ctl.tbClr   = supplyLow;
        if (!supplyLow && holdDone) stateNxt = ST_RUN;
      end
      default: begin
        goHold      = supplyLow || wdExpire;
        ctl.holdClr = 1'b1;
        ctl.wdEn    = 1'b1;
        ctl.wdClr   = wdFall;
        ctl.tbClr   = wdFall || goHold;
        if (goHold) stateNxt = ST_HOLD;
      end
    endcase
  end

  assign isRun = (state == ST_RUN);

  // R3: a low supply puts reset back on at the next edge
  p_low_to_hold_r3: assert property (@(posedge clk) disable iff (!porOk)
    supplyLow |=> !isRun);

  // R2: release only follows a completed hold-off with the supply good
  p_release_r2: assert property (@(posedge clk) disable iff (!porOk)
    $rose(isRun) |-> ($past(holdDone) && !$past(supplyLow)));

  // R9: an expiry while running drives reset active
  p_expire_r9: assert property (@(posedge clk) disable iff (!porOk)
    (isRun && wdExpire) |=> !isRun);

endmodule

// File: rtl/supv_reset_top.sv
module supv_reset_top
  import supv_pkg::*;
#(
  parameter int PRESCALE    = 125000,
  parameter int HOLD_TICKS  = 200,
  parameter int WD_SHORT    = 200,
  parameter int WD_MID      = 600,
  parameter int WD_LONG     = 1400,
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       porOk,
  input  logic       supplyLow,
  input  logic       wdIn,
  input  logic [1:0] wdSel,
  output logic       rstOutN,
  output logic       rstDriveEn
);

  ctlStrobe_t ctl;
  logic holdDone, wdExpire, wdFall, isRun;

  supv_datapath #(
    .PRESCALE   (PRESCALE),
    .HOLD_TICKS (HOLD_TICKS),
    .WD_SHORT   (WD_SHORT),
    .WD_MID     (WD_MID),
    .WD_LONG    (WD_LONG),
    .SYNC_STAGES(SYNC_STAGES)
  ) u_dp (
    .clk     (clk),
    .porOk   (porOk),
    .wdIn    (wdIn),
    .wdSel   (wdSel),
    .ctl     (ctl),
    .holdDone(holdDone),
    .wdExpire(wdExpire),
    .wdFall  (wdFall)
  );

  supv_control u_ctl (
    .clk      (clk),
    .porOk    (porOk),
    .supplyLow(supplyLow),
    .holdDone (holdDone),
    .wdExpire (wdExpire),
    .wdFall   (wdFall),
    .ctl      (ctl),
    .isRun    (isRun)
  );

  assign rstOutN    = isRun;
  assign rstDriveEn = !isRun;

  // R1: reset is active whenever the power-good flag is low
  p_por_reset_r1: assert property (@(posedge clk) !porOk |-> !rstOutN);

endmodule

// File: tb/tb_supv_reset_top.sv
module tb_supv_reset_top;

  localparam int P    = 3;
  localparam int HT   = 4;
  localparam int WS   = 5;
  localparam int WM   = 9;
  localparam int WL   = 14;
  localparam int HOLD_EDGES = HT * P;

  logic clk = 1'b0;
  logic porOk, supplyLow, wdIn;
  logic [1:0] wdSel;
  logic rstOutN, rstDriveEn;

  int nChk = 0;
  int nErr = 0;
  int invBad = 0;

  always #4 clk = ~clk;

  supv_reset_top #(
    .PRESCALE(P), .HOLD_TICKS(HT), .WD_SHORT(WS), .WD_MID(WM), .WD_LONG(WL),
    .SYNC_STAGES(2)
  ) dut (
    .clk(clk), .porOk(porOk), .supplyLow(supplyLow), .wdIn(wdIn),
    .wdSel(wdSel), .rstOutN(rstOutN), .rstDriveEn(rstDriveEn)
  );

  always @(negedge clk) if (rstDriveEn !== !rstOutN) invBad++;

  task automatic check(input string tag, input int act, input int exp);
    nChk++;
    if (act != exp) begin
      nErr++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic finishRun();
    check("R10 drive enable inverse mismatches", invBad, 0);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  endtask

  task automatic edgesUntil(input logic lvl, output int n);
    n = 0;
    while (rstOutN !== lvl && n < 2000) begin
      @(posedge clk); @(negedge clk); n++;
    end
  endtask

  task automatic waitEdges(input int k, output int lows);
    lows = 0;
    for (int i = 0; i < k; i++) begin
      @(posedge clk); @(negedge clk);
      if (rstOutN !== 1'b1) lows++;
    end
  endtask

  task automatic brownPulse();
    supplyLow = 1'b1;
    @(posedge clk); @(negedge clk);
    supplyLow = 1'b0;
  endtask

  initial begin
    int n, lows;
    int per [3];
    per[0] = WS; per[1] = WM; per[2] = WL;
    porOk = 1'b0; supplyLow = 1'b0; wdIn = 1'b1; wdSel = 2'b11;
    repeat (5) @(negedge clk);
    check("R1 rstOutN in power-on reset", int'(rstOutN), 0);
    check("R1 rstDriveEn in power-on reset", int'(rstDriveEn), 1);

    porOk = 1'b1;
    edgesUntil(1'b1, n);
    check("R2 power-up hold-off edges", n, HOLD_EDGES);

    supplyLow = 1'b1;
    @(posedge clk); @(negedge clk);
    check("R3 reset after supply low", int'(rstOutN), 0);
    waitEdges(30, lows);
    check("R4 reset held while supply low", lows, 30);
    supplyLow = 1'b0;
    edgesUntil(1'b1, n);
    check("R4 release after brownout", n, HOLD_EDGES);

    brownPulse();
    waitEdges(7, lows);
    check("R5 still in hold-off", lows, 7);
    supplyLow = 1'b1;
    repeat (2) begin @(posedge clk); @(negedge clk); end
    supplyLow = 1'b0;
    edgesUntil(1'b1, n);
    check("R5 hold-off restarted", n, HOLD_EDGES);

    for (int s = 0; s < 3; s++) begin
      wdSel = 2'(s);
      brownPulse();
      edgesUntil(1'b1, n);
      check("R6 release before watchdog run", n, HOLD_EDGES);
      edgesUntil(1'b0, n);
      check($sformatf("R6 expiry edges sel=%0d", s), n, per[s] * P);
      edgesUntil(1'b1, n);
      check("R9 watchdog reset length", n, HOLD_EDGES);
    end

    // late falling edge
    wdSel = 2'b00;
    waitEdges(5, lows);
    wdIn = 1'b0;
    edgesUntil(1'b0, n);
    check("R8 expiry after falling edge", n, 3 + WS * P);
    edgesUntil(1'b1, n);
    check("R9 release after watchdog", n, HOLD_EDGES);

    // rising edge does not restart
    waitEdges(4, lows);
    wdIn = 1'b1;
    edgesUntil(1'b0, n);
    check("R8 rising edge ignored", n, WS * P - 4);
    edgesUntil(1'b1, n);

    // periodic kicks keep reset released
    lows = 0;
    for (int k = 0; k < 5; k++) begin
      int l;
      waitEdges(6, l); lows += l;
      wdIn = 1'b0;
      waitEdges(6, l); lows += l;
      wdIn = 1'b1;
    end
    check("R8 kicks keep reset released", lows, 0);
    waitEdges(2, lows);
    wdIn = 1'b0;
    edgesUntil(1'b0, n);
    check("R8 expiry after last kick", n, 3 + WS * P);
    edgesUntil(1'b1, n);

    // watchdog off
    wdSel = 2'b11;
    waitEdges(3 * WL * P, lows);
    check("R7 no expiry while off", lows, 0);

    finishRun();
  end

  initial begin
    repeat (100000) @(posedge clk);
    nErr++;
    nChk++;
    $display("FAIL watchdog timeout actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", nChk, nErr);
    $finish;
  end

endmodule